// File: doc/BRIEF.md
# Bidirectional Token Pixel Loader

This block gathers the gray-scale words for the next display row into a buffer with one slot per column. It uses no address counter. A single token travels along the chain of column slots, one step per shift clock, and the slot group that holds the token captures the data bus on that edge. A direction input chooses which end the token enters from. The token leaves from the far end, so several loaders can be chained to cover a wide panel.

In single-bus mode, one 6-bit word on bus C fills one column per clock. In three-bus mode, buses A, B and C fill three adjacent columns per clock, so the token crosses the chip in a third of the clocks. A latch-enable pulse copies the finished buffer to the row output, which is held for the output stage. The next row can start loading as soon as latch-enable has been given. The column count is a parameter, 240 by default, and must be a multiple of three.

Top module: `pixel_token_loader`

## Requirements
- R1: After reset, `row_out` is all zeros, both token outputs are low, and every load slot is zero. A latch given straight after reset therefore yields zeros.
- R2: With `dir_ltr`=1, a high level on `tok_l_in` starts a load. On that same clock edge column 0 captures the bus, and each following edge captures the next column to the right. The exit pulse appears only on `tok_r_out`, and `tok_l_out` stays low.
- R3: With `dir_ltr`=0, a high level on `tok_r_in` starts a load with column NUM_COLS-1, and the load moves leftward. The exit pulse appears only on `tok_l_out`.
- R4: With `wide_mode`=0, each capture takes `bus_c`, and the token crosses the chip in NUM_COLS edges. The exit pin is high for exactly the one cycle that follows the edge of the last capture, and it is low during the load.
- R5: With `wide_mode`=1, each edge fills three adjacent columns. `bus_a` fills the first column in the direction of travel, `bus_b` the second and `bus_c` the third. The crossing takes NUM_COLS/3 edges, and the exit pulse follows the last group as in R4.
- R6: A token that arrives while a load is in progress is ignored. The load continues without restarting, and only one exit pulse is produced.
- R7: On a clock edge with `latch_en`=1, `row_out` takes the load buffer as it stood before that edge. Without `latch_en`, `row_out` does not change. A capture on the same edge as the latch goes into the load buffer and not into `row_out`.
- R8: Direction and mode are sampled when the token enters. Changing `dir_ltr` or `wide_mode` during a load has no effect on that load.
- R9: A token on the exit-side input is ignored: `tok_r_in` when `dir_ltr`=1, and `tok_l_in` when `dir_ltr`=0.
- R10: A slot keeps its value until a capture writes it. `row_out` packs column c at bits [c*6 +: 6].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_ltr | input | 1 | 1: token travels left to right; 0: right to left |
| wide_mode | input | 1 | 0: one word per clock on bus C; 1: three words per clock |
| tok_l_in | input | 1 | Token input at the left end |
| tok_r_in | input | 1 | Token input at the right end |
| tok_l_out | output | 1 | Token output at the left end (right-to-left travel) |
| tok_r_out | output | 1 | Token output at the right end (left-to-right travel) |
| bus_a | input | PIX_W | First word of a triple |
| bus_b | input | PIX_W | Second word of a triple |
| bus_c | input | PIX_W | Third word of a triple, or the single-bus word |
| latch_en | input | 1 | Copy the load buffer to `row_out` |
| row_out | output | NUM_COLS*PIX_W | Latched row, column c at [c*PIX_W +: PIX_W] |

## Verification
A latch and the final capture of a row can land on the same shift edge. In that case the output must receive the buffer without the final group, while the buffer itself keeps that group. The bench raises `latch_en` together with the last bus word. It compares `row_out` with a snapshot of its own buffer model taken before that write, and then latches again and expects the complete row. A second overlap is a new token arriving mid-row. It is driven on the entry pin in the middle of a three-bus load and judged by an unchanged row and a single exit pulse at the normal time.

// File: rtl/pixel_token_pkg.sv
package pixel_token_pkg;

  typedef enum logic [1:0] {
    LANE_A = 2'd0,
    LANE_B = 2'd1,
    LANE_C = 2'd2
  } lane_e;

  // Lane that feeds the slot at travel-order position s in three-bus mode
  function automatic lane_e lane_of(input int s);
    case (s % 3)
      0:       return LANE_A;
      1:       return LANE_B;
      default: return LANE_C;
    endcase
  endfunction

endpackage

// File: rtl/token_tracker.sv
module token_tracker #(
  parameter int NUM_COLS = 240,
  parameter int GW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_ltr,
  input  logic          wide_mode,
  input  logic          tok_l_in,
  input  logic          tok_r_in,
  output logic          cap_valid,
  output logic [GW-1:0] cap_grp,
  output logic          cap_dir,
  output logic          cap_wide,
  output logic          tok_l_out,
  output logic          tok_r_out
);
  localparam int GROUPS_SINGLE = NUM_COLS;
  localparam int GROUPS_WIDE   = NUM_COLS / 3;

  logic          active;
  logic [GW-1:0] grp;
  logic          cur_dir, cur_wide;
  logic          tok_l_q, tok_r_q;
  logic          tok_in_sel, start, cap_last;
  logic [GW-1:0] last_grp;

  always_comb begin
    tok_in_sel = dir_ltr ? tok_l_in : tok_r_in;
    start      = !active && tok_in_sel;
    cap_valid  = active || start;
    cap_grp    = active ? grp : '0;
    cap_dir    = active ? cur_dir : dir_ltr;
    cap_wide   = active ? cur_wide : wide_mode;
    last_grp   = cap_wide ? GW'(GROUPS_WIDE - 1) : GW'(GROUPS_SINGLE - 1);
    cap_last   = (cap_grp == last_grp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      grp      <= '0;
      cur_dir  <= 1'b1;
      cur_wide <= 1'b0;
      tok_l_q  <= 1'b0;
      tok_r_q  <= 1'b0;
    end else begin
      tok_l_q <= 1'b0;
      tok_r_q <= 1'b0;
      if (start) begin
        cur_dir  <= dir_ltr;
        cur_wide <= wide_mode;
      end
      if (cap_valid) begin
        if (cap_last) begin
          active  <= 1'b0;
          grp     <= '0;
          tok_r_q <= cap_dir;
          tok_l_q <= !cap_dir;
        end else begin
          active <= 1'b1;
          grp    <= cap_grp + 1'b1;
        end
      end
    end
  end

  assign tok_l_out = tok_l_q;
  assign tok_r_out = tok_r_q;

endmodule

// File: rtl/slot_bank.sv
module slot_bank
  import pixel_token_pkg::*;
#(
  parameter int NUM_COLS = 240,
  parameter int PIX_W    = 6,
  parameter int GW       = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_valid,
  input  logic [GW-1:0]             cap_grp,
  input  logic                      cap_dir,
  input  logic                      cap_wide,
  input  logic [PIX_W-1:0]          bus_a,
  input  logic [PIX_W-1:0]          bus_b,
  input  logic [PIX_W-1:0]          bus_c,
  output logic [NUM_COLS*PIX_W-1:0] load_row
);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int    POS_L  = c;
    localparam int    POS_R  = NUM_COLS - 1 - c;
    localparam lane_e LANE_L = lane_of(POS_L);
    localparam lane_e LANE_R = lane_of(POS_R);

    logic [GW-1:0]    my_grp;
    lane_e            my_lane;
    logic [PIX_W-1:0] din;
    logic [PIX_W-1:0] slot_q;

    always_comb begin
      if (cap_wide) begin
        my_grp  = cap_dir ? GW'(POS_L / 3) : GW'(POS_R / 3);
        my_lane = cap_dir ? LANE_L : LANE_R;
      end else begin
        my_grp  = cap_dir ? GW'(POS_L) : GW'(POS_R);
        my_lane = LANE_C;
      end
      case (my_lane)
        LANE_A:  din = bus_a;
        LANE_B:  din = bus_b;
        default: din = bus_c;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)
        slot_q <= '0;
      else if (cap_valid && (cap_grp == my_grp))
        slot_q <= din;
    end

    assign load_row[c*PIX_W +: PIX_W] = slot_q;
  end

endmodule

// File: rtl/row_latch.sv
module row_latch #(
  parameter int WIDTH = 1440
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (latch_en)
      q <= d;
  end
endmodule

// File: rtl/pixel_token_loader.sv
module pixel_token_loader #(
  parameter int NUM_COLS = 240,
  parameter int PIX_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dir_ltr,
  input  logic                      wide_mode,
  input  logic                      tok_l_in,
  input  logic                      tok_r_in,
  output logic                      tok_l_out,
  output logic                      tok_r_out,
  input  logic [PIX_W-1:0]          bus_a,
  input  logic [PIX_W-1:0]          bus_b,
  input  logic [PIX_W-1:0]          bus_c,
  input  logic                      latch_en,
  output logic [NUM_COLS*PIX_W-1:0] row_out
);
  localparam int GW    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int ROW_W = NUM_COLS * PIX_W;

  logic             cap_valid, cap_dir, cap_wide;
  logic [GW-1:0]    cap_grp;
  logic [ROW_W-1:0] load_row;

  token_tracker #(.NUM_COLS(NUM_COLS), .GW(GW)) i_tracker (
    .clk(clk), .rst(rst), .dir_ltr(dir_ltr), .wide_mode(wide_mode),
    .tok_l_in(tok_l_in), .tok_r_in(tok_r_in),
    .cap_valid(cap_valid), .cap_grp(cap_grp), .cap_dir(cap_dir),
    .cap_wide(cap_wide), .tok_l_out(tok_l_out), .tok_r_out(tok_r_out)
  );

  slot_bank #(.NUM_COLS(NUM_COLS), .PIX_W(PIX_W), .GW(GW)) i_slots (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_grp(cap_grp),
    .cap_dir(cap_dir), .cap_wide(cap_wide),
    .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c), .load_row(load_row)
  );

  row_latch #(.WIDTH(ROW_W)) i_latch (
    .clk(clk), .rst(rst), .latch_en(latch_en), .d(load_row), .q(row_out)
  );

endmodule

// File: rtl/pixel_token_loader_chk.sv
module pixel_token_loader_chk #(
  parameter int NUM_COLS = 240,
  parameter int PIX_W    = 6,
  parameter int GW       = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      latch_en,
  input logic                      tok_l_out,
  input logic                      tok_r_out,
  input logic [NUM_COLS*PIX_W-1:0] row_out,
  input logic [NUM_COLS*PIX_W-1:0] load_row,
  input logic                      cap_valid,
  input logic [GW-1:0]             cap_grp,
  input logic                      cap_dir,
  input logic                      cap_wide
);

  assert_exit_pins_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(tok_l_out && tok_r_out));

  assert_right_exit_after_capture_R2: assert property (@(posedge clk) disable iff (rst)
    tok_r_out |-> ($past(cap_valid) && $past(cap_dir)));

  assert_left_exit_after_capture_R3: assert property (@(posedge clk) disable iff (rst)
    tok_l_out |-> ($past(cap_valid) && !$past(cap_dir)));

  assert_right_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    tok_r_out |=> !tok_r_out);

  assert_left_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    tok_l_out |=> !tok_l_out);

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && cap_grp != '0) |-> (cap_grp == GW'($past(cap_grp) + 1'b1)));

  assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(row_out));

  assert_row_take_R7: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (row_out == $past(load_row)));

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && cap_grp != '0) |->
      (cap_dir == $past(cap_dir) && cap_wide == $past(cap_wide)));

endmodule

bind pixel_token_loader pixel_token_loader_chk #(
  .NUM_COLS(NUM_COLS), .PIX_W(PIX_W), .GW(GW)
) i_chk (
  .clk(clk), .rst(rst), .latch_en(latch_en), .tok_l_out(tok_l_out),
  .tok_r_out(tok_r_out), .row_out(row_out), .load_row(load_row),
  .cap_valid(cap_valid), .cap_grp(cap_grp), .cap_dir(cap_dir),
  .cap_wide(cap_wide)
);

// File: tb/test_pixel_token_loader.sv
module test_pixel_token_loader;
  localparam int N     = 12;
  localparam int W     = 6;
  localparam int ROW_W = N * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_ltr = 1'b1, wide_mode = 1'b0;
  logic tok_l_in = 1'b0, tok_r_in = 1'b0, latch_en = 1'b0;
  logic tok_l_out, tok_r_out;
  logic [W-1:0] bus_a = '0, bus_b = '0, bus_c = '0;
  logic [ROW_W-1:0] row_out;

  logic [ROW_W-1:0] mbuf = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pixel_token_loader #(.NUM_COLS(N), .PIX_W(W)) i_pixel_token_loader (
    .clk(clk), .rst(rst), .dir_ltr(dir_ltr), .wide_mode(wide_mode),
    .tok_l_in(tok_l_in), .tok_r_in(tok_r_in),
    .tok_l_out(tok_l_out), .tok_r_out(tok_r_out),
    .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c),
    .latch_en(latch_en), .row_out(row_out)
  );

  // {dir, wide, seed}
  localparam logic [9:0] VEC [0:3] = '{
    {1'b1, 1'b0, 8'd1}, {1'b0, 1'b0, 8'd2},
    {1'b1, 1'b1, 8'd3}, {1'b0, 1'b1, 8'd4}
  };

  function automatic logic [W-1:0] pat(input int seed, input int k, input int lane);
    return W'(seed * 11 + k * 5 + lane * 23 + 1);
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_row(input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp,
                         input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model write of step k per R2/R3/R4/R5
  task automatic model_step(input bit d, input bit w, input int seed, input int k);
    if (w) begin
      for (int l = 0; l < 3; l++) begin
        int s = 3 * k + l;
        int col = d ? s : N - 1 - s;
        mbuf[col*W +: W] = pat(seed, k, l);
      end
    end else begin
      int col = d ? k : N - 1 - k;
      mbuf[col*W +: W] = pat(seed, k, 2);
    end
  endtask

  task automatic load_row(input bit d, input bit w, input int seed, input int extra_at,
                          input int flip_at, input int latch_at, input string req);
    int g = w ? N / 3 : N;
    logic [ROW_W-1:0] snap = '0;
    for (int k = 0; k < g; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk_bit(tok_l_out, 1'b0, "R4 exit low during load");
        chk_bit(tok_r_out, 1'b0, "R4 exit low during load");
      end
      dir_ltr   = (flip_at >= 0 && k >= flip_at) ? ~d : d;
      wide_mode = (flip_at >= 0 && k >= flip_at) ? ~w : w;
      tok_l_in  = d && (k == 0 || k == extra_at);
      tok_r_in  = !d && (k == 0 || k == extra_at);
      bus_a = pat(seed, k, 0);
      bus_b = pat(seed, k, 1);
      bus_c = pat(seed, k, 2);
      latch_en = (k == latch_at);
      if (k == latch_at) snap = mbuf;
      model_step(d, w, seed, k);
    end
    @(negedge clk);
    tok_l_in = 1'b0; tok_r_in = 1'b0; latch_en = 1'b0;
    dir_ltr = d; wide_mode = w;
    chk_bit(d ? tok_r_out : tok_l_out, 1'b1, req);
    chk_bit(d ? tok_l_out : tok_r_out, 1'b0, req);
    if (latch_at >= 0) chk_row(row_out, snap, "R7 latch coincident with last capture");
    @(negedge clk);
    chk_bit(tok_r_out | tok_l_out, 1'b0, "R4 exit pulse one cycle");
  endtask

  task automatic latch_check(input string req);
    @(negedge clk);
    latch_en = 1'b1;
    @(negedge clk);
    latch_en = 1'b0;
    chk_row(row_out, mbuf, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_row(row_out, '0, "R1 row_out after reset");
    chk_bit(tok_l_out, 1'b0, "R1 tok_l_out after reset");
    chk_bit(tok_r_out, 1'b0, "R1 tok_r_out after reset");
    latch_check("R1 slots zero after reset");

    for (int i = 0; i < 4; i++) begin
      bit d = VEC[i][9];
      bit w = VEC[i][8];
      load_row(d, w, int'(VEC[i][7:0]), -1, -1, -1,
               w ? "R5 three-bus exit pulse" : (d ? "R2 right exit" : "R3 left exit"));
      latch_check(w ? "R5 three-bus row" : (d ? "R2 left-to-right row" : "R3 right-to-left row"));
    end

    // R6: second token mid-row ignored
    load_row(1'b0, 1'b1, 9, 2, -1, -1, "R6 single exit pulse with extra token");
    latch_check("R6 row unaffected by extra token");

    // R8: direction/mode change mid-row has no effect
    load_row(1'b1, 1'b0, 13, -1, 3, -1, "R8 exit pin fixed at entry");
    latch_check("R8 row unaffected by mode change");

    // R7: latch on last capture edge
    load_row(1'b1, 1'b0, 21, -1, -1, N - 1, "R7 exit with coincident latch");
    latch_check("R7 full row after second latch");

    // R9/R10: exit-side token ignored, slots hold
    @(negedge clk);
    dir_ltr = 1'b1; tok_r_in = 1'b1; bus_a = 6'h3f; bus_b = 6'h3f; bus_c = 6'h3f;
    @(negedge clk);
    tok_r_in = 1'b0;
    repeat (2) @(negedge clk);
    chk_bit(tok_l_out | tok_r_out, 1'b0, "R9 right input ignored when dir_ltr=1");
    dir_ltr = 1'b0; tok_l_in = 1'b1;
    @(negedge clk);
    tok_l_in = 1'b0;
    repeat (2) @(negedge clk);
    chk_bit(tok_l_out | tok_r_out, 1'b0, "R9 left input ignored when dir_ltr=0");
    chk_row(row_out, mbuf, "R7 row_out holds without latch");
    latch_check("R10 slots unchanged without token");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule